// File: doc/BRIEF.md
# Two-Level Fair Bus Arbiter

This block is the central grant logic for a shared parallel bus with up to eight masters. Every master owns one active-low request line and one active-low grant line. A static mask puts each master in a high tier or a low tier. The high tier is served in round-robin order. The low tier as a whole takes one seat in that rotation, and it has its own round-robin order among its members. As a result, a busy low-tier master can never be starved by the high tier, and a high-tier master always reaches the bus sooner than any one low-tier master.

The arbiter watches the frame and initiator-ready lines. A master starts a transaction when the frame line goes low in the cycle after both lines were high. That start event counts as the grantee having used its grant, so the grant moves on to the next requester, even while the transaction is still running. The new grantee then waits for the bus to go idle before it starts. When nobody requests, the grant parks on the master that started the most recent transaction, so that master can begin again without first raising its request. All grant changes are registered, so the grant output always changes one clock after the inputs that caused it.

Top module: `duo_tier_arbiter`

## Requirements
- R1: Exactly one bit of `gnt_n` is low in every cycle; bit i is the grant for master i.
- R2: After reset, with no requests, `gnt_n` grants master 0 and master 0 counts as the last owner.
- R3: While the current grantee keeps its `req_n` bit low and no transaction starts, the grant does not change.
- R4: When the grantee's `req_n` bit is high and some other bit is low, the grant moves to a requesting master on the next clock.
- R5: A start event is `frame_n` low in a cycle that follows a cycle with both `frame_n` and `irdy_n` high. A start event triggers re-arbitration one clock later, even though the bus is then busy. A bus that merely stays busy triggers nothing.
- R6: With masters 0 and 1 high-tier (mask bits 0 and 1 set) and 0, 1, 2, 3 all requesting from reset, successive start events give the grant sequence 0, 1, 2, 0, 1, 3, 0.
- R7: With only one high-tier master (1) and one low-tier master (5) requesting, the grant alternates 1, 5, 1, 5.
- R8: With only low-tier masters (2 and 4) requesting, they alternate round-robin: 2, 4, 2, 4.
- R9: With no request low, the grant parks on the master that was granted in the cycle before the last start event, not on the most recent grantee.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_n | input | N_MASTERS | Per-master request, active low |
| frame_n | input | 1 | Bus frame line, active low |
| irdy_n | input | 1 | Initiator ready line, active low |
| gnt_n | output | N_MASTERS | Per-master grant, active low, one-hot |

## Verification
The hardest case to reach is parking on the last owner rather than on the last grantee. To set it up, the grant must first go to a master that then starts a transaction and lets go of its request. A second master must then be granted without ever starting, and finally every request must drop. The bench builds this sequence step by step and times the start events so that frame goes low a full cycle after the grant became visible, the same way a real master samples its grant. The fairness sequences are reached the same way: the requests are held steady and one start event is issued at a time from an idle bus.

// File: rtl/tier_arb_pkg.sv
`timescale 1ns/1ps
package tier_arb_pkg;
   typedef enum logic [1:0] {
      ACT_HOLD = 2'd0,
      ACT_PASS = 2'd1,
      ACT_PARK = 2'd2
   } arb_act_e;
endpackage

// File: rtl/tier_rr_pick.sv
`timescale 1ns/1ps
module tier_rr_pick #(
   parameter int WIDTH = 8,
   parameter int IW    = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
   input  logic [WIDTH-1:0] req,
   input  logic [IW-1:0]    last,
   output logic             found,
   output logic [IW-1:0]    idx
);
   if (WIDTH < 2) begin : g_bad_width
      $error("tier_rr_pick: WIDTH must be at least 2");
   end

   always_comb begin
      found = |req;
      idx   = '0;
      // Scan from farthest to nearest so the nearest requester after last wins.
      for (int k = WIDTH; k >= 1; k--) begin
         int pos;
         pos = (int'(last) + k) % WIDTH;
         if (req[pos]) idx = IW'(pos);
      end
   end
endmodule

// File: rtl/bus_start_detect.sv
`timescale 1ns/1ps
module bus_start_detect (
   input  logic clk,
   input  logic rst_n,
   input  logic frame_n,
   input  logic irdy_n,
   output logic start
);
   logic idle_d1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) idle_d1 <= 1'b1;
      else        idle_d1 <= frame_n & irdy_n;
   end

   assign start = idle_d1 & ~frame_n;

   // R5: a start needs an idle cycle before it, so two never come back to back
   a_r5_single_start: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> !start);
endmodule

// File: rtl/duo_tier_arbiter.sv
`timescale 1ns/1ps
module duo_tier_arbiter #(
   parameter int                  N_MASTERS = 8,
   parameter logic [N_MASTERS-1:0] HI_MASK  = N_MASTERS'(3)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [N_MASTERS-1:0] req_n,
   input  logic                 frame_n,
   input  logic                 irdy_n,
   output logic [N_MASTERS-1:0] gnt_n
);
   import tier_arb_pkg::*;

   localparam int IDX_W  = $clog2(N_MASTERS);
   localparam int SLOT_N = N_MASTERS + 1;
   localparam int SLOT_W = $clog2(SLOT_N);
   localparam logic [SLOT_W-1:0] LOW_SLOT = SLOT_W'(N_MASTERS);
   localparam logic [SLOT_W-1:0] HP_RST   = HI_MASK[0] ? '0 : LOW_SLOT;
   localparam logic [IDX_W-1:0]  LP_RST   = HI_MASK[0] ? IDX_W'(N_MASTERS - 1) : '0;

   if (N_MASTERS < 2 || N_MASTERS > 32) begin : g_bad_count
      $error("duo_tier_arbiter: N_MASTERS must be within 2..32");
   end

   logic [N_MASTERS-1:0] req;
   logic [N_MASTERS-1:0] lo_req;
   logic [SLOT_N-1:0]    hi_req;
   logic                 start;

   logic [IDX_W-1:0]  gidx_q, gidx_d1, owner_q, owner_nx, g_nx, lp_q, lo_idx;
   logic [SLOT_W-1:0] hp_q, hi_idx;
   logic              hi_found, lo_found;
   logic [N_MASTERS-1:0] gnt_n_q;
   arb_act_e          act;

   assign req    = ~req_n;
   assign lo_req = req & ~HI_MASK;
   assign hi_req = {|lo_req, req & HI_MASK};

   bus_start_detect u_start (
      .clk     (clk),
      .rst_n   (rst_n),
      .frame_n (frame_n),
      .irdy_n  (irdy_n),
      .start   (start)
   );

   tier_rr_pick #(.WIDTH(SLOT_N), .IW(SLOT_W)) u_hi_pick (
      .req   (hi_req),
      .last  (hp_q),
      .found (hi_found),
      .idx   (hi_idx)
   );

   tier_rr_pick #(.WIDTH(N_MASTERS), .IW(IDX_W)) u_lo_pick (
      .req   (lo_req),
      .last  (lp_q),
      .found (lo_found),
      .idx   (lo_idx)
   );

   // The master that began the transaction saw the grant one cycle earlier.
   assign owner_nx = start ? gidx_d1 : owner_q;

   always_comb begin
      if (req == '0) begin
         act  = ACT_PARK;
         g_nx = owner_nx;
      end else if (!req[gidx_q] || start) begin
         act  = ACT_PASS;
         if (hi_found && hi_idx != LOW_SLOT) g_nx = IDX_W'(hi_idx);
         else if (lo_found)                  g_nx = lo_idx;
         else                                g_nx = gidx_q;
      end else begin
         act  = ACT_HOLD;
         g_nx = gidx_q;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gidx_q  <= '0;
         gidx_d1 <= '0;
         owner_q <= '0;
         gnt_n_q <= ~N_MASTERS'(1);
         hp_q    <= HP_RST;
         lp_q    <= LP_RST;
      end else begin
         gidx_d1 <= gidx_q;
         owner_q <= owner_nx;
         gidx_q  <= g_nx;
         gnt_n_q <= ~(N_MASTERS'(1) << g_nx);
         if (act != ACT_HOLD) begin
            if (HI_MASK[g_nx]) begin
               hp_q <= SLOT_W'(g_nx);
            end else begin
               hp_q <= LOW_SLOT;
               lp_q <= g_nx;
            end
         end
      end
   end

   assign gnt_n = gnt_n_q;

   // R1: one grant at a time
   a_r1_one_grant: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(~gnt_n) == 1);

   // R3: a requesting grantee keeps the bus until it starts a transaction
   a_r3_hold_grant: assert property (@(posedge clk) disable iff (!rst_n)
      (req[gidx_q] && !start) |=> $stable(gidx_q));

   // R4: an idle grantee loses the grant to a requester
   a_r4_move_away: assert property (@(posedge clk) disable iff (!rst_n)
      (!req[gidx_q] && (|req)) |=> (gidx_q != $past(gidx_q)));

   // R9: with no requests the grant returns to the last owner
   a_r9_park_owner: assert property (@(posedge clk) disable iff (!rst_n)
      ((req == '0) && !start) |=> (gidx_q == $past(owner_q)));

   // R6: the low-tier pointer only moves onto a master that is granted
   a_r6_low_ptr_granted: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(lp_q) |-> (gidx_q == lp_q));
endmodule

// File: tb/duo_tier_arbiter_bench.sv
`timescale 1ns/1ps
module duo_tier_arbiter_bench;
   localparam int N = 8;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [N-1:0] req_n = '1;
   logic         frame_n = 1'b1;
   logic         irdy_n = 1'b1;
   logic [N-1:0] gnt_n;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   duo_tier_arbiter #(.N_MASTERS(N), .HI_MASK(8'b0000_0011)) u_duo_tier_arbiter (
      .clk     (clk),
      .rst_n   (rst_n),
      .req_n   (req_n),
      .frame_n (frame_n),
      .irdy_n  (irdy_n),
      .gnt_n   (gnt_n)
   );

   // R1 monitored on every cycle after reset
   always @(negedge clk) begin
      if (rst_n && !done && $countones(~gnt_n) != 1) begin
         errors++;
         $display("FAIL R1 grant count actual %0d expected 1", $countones(~gnt_n));
      end
   end

   task automatic check_gnt(input int exp, input string tag);
      logic [N-1:0] want;
      want = ~(N'(1) << exp);
      checks++;
      if (gnt_n !== want) begin
         errors++;
         $display("FAIL %s gnt_n actual %b expected %b", tag, gnt_n, want);
      end
   endtask

   task automatic set_req(input logic [N-1:0] m);
      req_n = ~m;
   endtask

   task automatic do_reset();
      req_n   = '1;
      frame_n = 1'b1;
      irdy_n  = 1'b1;
      rst_n   = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   // One short transaction by the current grantee, begun from an idle bus.
   task automatic run_txn();
      @(negedge clk);
      frame_n = 1'b0;
      @(negedge clk);
      frame_n = 1'b1;
   endtask

   task automatic t_reset();
      do_reset();
      check_gnt(0, "R2");
      repeat (3) @(negedge clk);
      check_gnt(0, "R2");
      checks++;
      if ($countones(~gnt_n) != 1) begin
         errors++;
         $display("FAIL R1 grant count actual %0d expected 1", $countones(~gnt_n));
      end
   endtask

   task automatic t_fair();
      int exp_seq[7] = '{0, 1, 2, 0, 1, 3, 0};
      do_reset();
      set_req(8'b0000_1111);
      repeat (2) @(negedge clk);
      check_gnt(0, "R3");
      for (int i = 0; i < 7; i++) begin
         check_gnt(exp_seq[i], "R6");
         if (i < 6) run_txn();
      end
   endtask

   task automatic t_alt();
      int exp_seq[4] = '{1, 5, 1, 5};
      do_reset();
      set_req(8'b0010_0010);
      @(negedge clk);
      for (int i = 0; i < 4; i++) begin
         check_gnt(exp_seq[i], "R7");
         if (i < 3) run_txn();
      end
   endtask

   task automatic t_low_only();
      int exp_seq[4] = '{2, 4, 2, 4};
      do_reset();
      set_req(8'b0001_0100);
      @(negedge clk);
      for (int i = 0; i < 4; i++) begin
         check_gnt(exp_seq[i], "R8");
         if (i < 3) run_txn();
      end
   endtask

   task automatic t_drop();
      do_reset();
      set_req(8'b0000_1001);
      repeat (3) @(negedge clk);
      check_gnt(0, "R3");
      set_req(8'b0000_1000);
      @(negedge clk);
      check_gnt(3, "R4");
      set_req(8'b0100_1000);
      repeat (2) @(negedge clk);
      check_gnt(3, "R3");
   endtask

   task automatic t_busy();
      do_reset();
      set_req(8'b0000_0011);
      @(negedge clk);
      check_gnt(0, "R3");
      frame_n = 1'b0;
      @(negedge clk);
      check_gnt(1, "R5");
      irdy_n = 1'b0;
      repeat (3) @(negedge clk);
      check_gnt(1, "R5");
      frame_n = 1'b1;
      @(negedge clk);
      irdy_n = 1'b1;
      @(negedge clk);
      check_gnt(1, "R5");
      @(negedge clk);
      check_gnt(1, "R5");
   endtask

   task automatic t_park();
      do_reset();
      set_req(8'b0000_1000);
      @(negedge clk);
      check_gnt(3, "R4");
      @(negedge clk);
      frame_n = 1'b0;
      set_req(8'b0000_0000);
      @(negedge clk);
      frame_n = 1'b1;
      check_gnt(3, "R9");
      @(negedge clk);
      set_req(8'b0010_0000);
      @(negedge clk);
      check_gnt(5, "R4");
      set_req(8'b0000_0000);
      @(negedge clk);
      check_gnt(3, "R9");
      run_txn();
      @(negedge clk);
      check_gnt(3, "R9");
   endtask

   initial begin
      t_reset();
      t_fair();
      t_alt();
      t_low_only();
      t_drop();
      t_busy();
      t_park();
      if (!done) begin
         done = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog actual hung expected finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule